// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array

This block is a synthesizable 16K x 1 bit memory with the pin behaviour of a dynamic memory whose address is split in time. The seven address pins carry two halves of one address. The row half is captured when the row strobe falls, and the column half is captured when the column strobe falls later in the same row cycle. The storage is 128 rows of 128 single-bit cells. A row index and a column index select one cell, which is then read or written. All strobes are sampled on the system clock, so a strobe edge is the first clock in which the level is seen low after a clock in which it was high.

A controller or testbench drives the strobes the way it would drive a real part. A row cycle in which no column access happens serves as a refresh of the latched row. Any number of column cycles may share one open row. Charge loss is not modelled. Instead, each row that has been touched since reset keeps an age count. A sticky flag shows that some row went longer than a parameterised number of clocks without a refresh or access. This lets a test judge the refresh coverage of a controller.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset, `dout` is 0 and `age_err` is 0.
- R2: On a row-strobe falling edge (`ras_n` seen 0 after a clock at 1), `addr` is stored as the row index. On an accepted column-strobe falling edge, `addr` is the column index. The cell used is bit [column] of row [row].
- R3: A column-strobe fall is accepted only when `ras_n` was already 0 at the previous clock and is still 0. A `cas_n` fall while `ras_n` is high, in the same clock as the `ras_n` fall, or a `cas_n` already low before the `ras_n` fall, neither writes nor reads.
- R4: An accepted column fall with `cs_n` = 0 and `rw` = 0 writes `din` into the selected cell.
- R5: `dout` shows the selected cell while `ras_n`, `cas_n` and `cs_n` are all 0 and `rw` = 1, from the clock after the accepted column fall onward. At every other time, `dout` is 0.
- R6: With `cs_n` = 1 at the column fall, no cell is written.
- R7: A row cycle with no column access changes no cell.
- R8: A row becomes tracked at its first row fall, or at its first selected column access, after reset. A tracked row raises `age_err` if more than AGE_LIMIT+1 clocks pass between two of its touches. A touch that lands on exactly clock AGE_LIMIT+1 is in time and wins over expiry.
- R9: `age_err` stays at 1 until reset, whatever the later traffic.
- R10: Several column cycles may follow one row fall, and each uses the held row index. Raising `ras_n` ends any column access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 7 | Shared address pins: row half, then column half |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 when idle |
| age_err | output | 1 | Sticky flag: a tracked row went too long without refresh |

## Verification
Two functions can meet in one clock: the row age counter reaching its limit, and a refresh of that same row. The bench arms a row, then places the next row-only cycles exactly AGE_LIMIT+1 clocks apart, so each refresh lands on the clock where expiry would otherwise fire. It judges that `age_err` stays low. A second run puts the refresh one clock later and judges that the flag rises and then stays high.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

  // Strobe events derived from the sampled strobe levels.
  typedef struct packed {
    logic ras_fall;   // row strobe newly low this clock
    logic cas_fall;   // accepted column strobe fall this clock
    logic col_open;   // a column access is in progress
  } strobe_ev_t;

endpackage

// File: rtl/mdram_strobe.sv
module mdram_strobe
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output strobe_ev_t        ev
);

  logic              ras_q, cas_q, open_q;
  logic              ras_fall, cas_fall, open_d;
  logic [ADDR_W-1:0] row_d, col_d;

  // next-state
  always_comb begin
    ras_fall = ras_q & ~ras_n;
    // column fall counts only inside an already-open row
    cas_fall = cas_q & ~cas_n & ~ras_q & ~ras_n;
    row_d    = ras_fall ? addr : row_q;
    col_d    = cas_fall ? addr : col_q;
    if (ras_n || cas_n)  open_d = 1'b0;
    else if (cas_fall)   open_d = 1'b1;
    else                 open_d = open_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      open_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      open_q <= open_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign ev.ras_fall = ras_fall;
  assign ev.cas_fall = cas_fall;
  assign ev.col_open = open_q;

endmodule

// File: rtl/mdram_cells.sv
module mdram_cells #(
  parameter int ADDR_W = 7,
  localparam int ROWS  = 1 << ADDR_W,
  localparam int COLS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_row,
  input  logic [ADDR_W-1:0] wr_col,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_row,
  input  logic [ADDR_W-1:0] rd_col,
  output logic              rd_bit
);

  // one word per row, one bit per column
  logic [COLS-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem_q[wr_row][wr_col] <= wr_bit;
  end

  always_comb rd_bit = mem_q[rd_row][rd_col];

endmodule

// File: rtl/mdram_age.sv
module mdram_age #(
  parameter int ADDR_W    = 7,
  parameter int AGE_LIMIT = 1000,
  localparam int ROWS     = 1 << ADDR_W,
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [ADDR_W-1:0] touch_row,
  output logic              err
);

  localparam logic [AGE_W-1:0] LIMIT_V = AGE_W'(AGE_LIMIT);

  logic [ROWS-1:0] expire;
  logic            err_q, err_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [ADDR_W-1:0] ME = ADDR_W'(r);
    logic             armed_q, armed_d, hit;
    logic [AGE_W-1:0] age_q, age_d;

    always_comb begin
      hit     = touch && (touch_row == ME);
      armed_d = armed_q | hit;
      age_d   = age_q;
      expire[r] = 1'b0;
      if (hit)                    age_d = '0;
      else if (armed_q) begin
        if (age_q == LIMIT_V)     expire[r] = 1'b1;
        else                      age_d = age_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b0;
        age_q   <= '0;
      end else begin
        armed_q <= armed_d;
        age_q   <= age_d;
      end
    end
  end

  always_comb err_d = err_q | (|expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int AGE_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              rw,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              age_err
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  logic [ADDR_W-1:0] row_lat, col_lat, touch_row;
  strobe_ev_t        ev;
  logic              cell_we, rd_bit, touch, cs_act;
  logic              ras_fall_w, col_open_w;

  mdram_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .addr  (addr),
    .row_q (row_lat),
    .col_q (col_lat),
    .ev    (ev)
  );

  always_comb begin
    cs_act     = ~cs_n;
    ras_fall_w = ev.ras_fall;
    col_open_w = ev.col_open;
    cell_we    = ev.cas_fall & cs_act & ~rw;
    touch      = ev.ras_fall | (ev.cas_fall & cs_act);
    touch_row  = ev.ras_fall ? addr : row_lat;
  end

  mdram_cells #(.ADDR_W(ADDR_W)) u_cells (
    .clk    (clk),
    .we     (cell_we),
    .wr_row (row_lat),
    .wr_col (addr),
    .wr_bit (din),
    .rd_row (row_lat),
    .rd_col (col_lat),
    .rd_bit (rd_bit)
  );

  mdram_age #(.ADDR_W(ADDR_W), .AGE_LIMIT(AGE_LIMIT)) u_age (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .touch     (touch),
    .touch_row (touch_row),
    .err       (age_err)
  );

  always_comb
    dout = (col_open_w & ~ras_n & ~cas_n & cs_act & rw) ? rd_bit : 1'b0;

endmodule

// File: rtl/mux_addr_dram_chk.sv
module mux_addr_dram_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ras_n,
  input logic              cas_n,
  input logic              rw,
  input logic              cs_n,
  input logic              dout,
  input logic              age_err,
  input logic              cell_we,
  input logic              ras_fall,
  input logic              col_open,
  input logic [ADDR_W-1:0] row_lat
);

  assert_idle_dout_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cas_n || ras_n || cs_n || !rw) |-> (dout == 1'b0));

  assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cell_we |-> (!cas_n && !ras_n && !cs_n && !rw));

  assert_no_write_cs_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |-> !cell_we);

  assert_refresh_no_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cas_n |-> !cell_we);

  assert_row_capture_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ras_fall |=> (row_lat == $past(addr)));

  assert_col_close_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ras_n |=> !col_open);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    age_err |=> age_err);

endmodule

bind mux_addr_dram mux_addr_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_q_n),
  .addr       (addr),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .rw         (rw),
  .cs_n       (cs_n),
  .dout       (dout),
  .age_err    (age_err),
  .cell_we    (cell_we),
  .ras_fall   (ras_fall_w),
  .col_open   (col_open_w),
  .row_lat    (row_lat)
);

// File: tb/tb_mux_addr_dram.sv
`timescale 1ns/1ps
module tb_mux_addr_dram;

  localparam int AW    = 7;
  localparam int LIM   = 40;
  localparam int NVEC  = 10;
  // fields: row [14:8], col [7:1], data [0]
  localparam logic [14:0] VEC [NVEC] = '{
    {7'd0,   7'd0,   1'b1},
    {7'd0,   7'd127, 1'b1},
    {7'd127, 7'd0,   1'b1},
    {7'd127, 7'd127, 1'b0},
    {7'd64,  7'd5,   1'b1},
    {7'd64,  7'd6,   1'b0},
    {7'd3,   7'd3,   1'b1},
    {7'd3,   7'd3,   1'b0},
    {7'd100, 7'd77,  1'b1},
    {7'd127, 7'd127, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ras_n, cas_n, rw, cs_n, din;
  logic          dout, age_err;
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;

  always #4 clk = ~clk;

  mux_addr_dram #(.ADDR_W(AW), .AGE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .rw(rw), .cs_n(cs_n), .din(din), .dout(dout), .age_err(age_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
    din = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cell(input logic [AW-1:0] r, input logic [AW-1:0] c,
                            input logic d, input logic sel_n);
    @(negedge clk); addr = r; ras_n = 1'b0; cs_n = sel_n; rw = 1'b0;
    @(negedge clk); addr = c; din = d; cas_n = 1'b0;
    @(negedge clk); cas_n = 1'b1; ras_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
  endtask

  task automatic read_cell(input logic [AW-1:0] r, input logic [AW-1:0] c,
                           input logic sel_n, output logic val);
    @(negedge clk); addr = r; ras_n = 1'b0; cs_n = sel_n; rw = 1'b1;
    @(negedge clk); addr = c; cas_n = 1'b0;
    chk("R5 dout idle before column accepted", dout, 1'b0);
    @(negedge clk); val = dout; cas_n = 1'b1; ras_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    @(negedge clk); addr = r; ras_n = 1'b0; cs_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
  endtask

  function automatic logic expect_bit(input logic [AW-1:0] r, input logic [AW-1:0] c);
    logic v = 1'b0;
    for (int i = 0; i < NVEC; i++)
      if (VEC[i][14:8] == r && VEC[i][7:1] == c) v = VEC[i][0];
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic v;
    // ---- R1 reset state
    do_reset();
    chk("R1 dout after reset", dout, 1'b0);
    chk("R1 age_err after reset", age_err, 1'b0);

    // ---- R8 refresh exactly on the expiry clock is in time
    ras_only(7'd5);
    repeat (LIM - 1) @(negedge clk);
    ras_only(7'd5);
    repeat (LIM - 1) @(negedge clk);
    ras_only(7'd5);
    repeat (2) @(negedge clk);
    chk("R8 refresh at limit+1 clocks keeps flag low", age_err, 1'b0);
    repeat (LIM + 5) @(negedge clk);
    chk("R8 unrefreshed tracked row raises flag", age_err, 1'b1);
    ras_only(7'd5);
    repeat (10) @(negedge clk);
    chk("R9 flag stays after refresh", age_err, 1'b1);
    do_reset();
    chk("R1 flag cleared by reset", age_err, 1'b0);

    // ---- R8 one clock late
    ras_only(7'd9);
    repeat (LIM) @(negedge clk);
    ras_only(7'd9);
    chk("R8 refresh one clock late raises flag", age_err, 1'b1);

    // ---- R2/R4/R5 table walk
    do_reset();
    for (int i = 0; i < NVEC; i++)
      write_cell(VEC[i][14:8], VEC[i][7:1], VEC[i][0], 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      read_cell(VEC[i][14:8], VEC[i][7:1], 1'b0, v);
      chk($sformatf("R2 R4 R5 vector %0d read", i), v,
          expect_bit(VEC[i][14:8], VEC[i][7:1]));
    end

    // ---- R10 page mode: two columns in one row cycle, then close
    @(negedge clk); addr = 7'd64; ras_n = 1'b0; cs_n = 1'b0; rw = 1'b1;
    @(negedge clk); addr = 7'd5; cas_n = 1'b0;
    @(negedge clk); chk("R10 page col 5", dout, 1'b1); cas_n = 1'b1;
    @(negedge clk); addr = 7'd6; cas_n = 1'b0;
    @(negedge clk); chk("R10 page col 6", dout, 1'b0); cas_n = 1'b1;
    @(negedge clk); addr = 7'd5; cas_n = 1'b0;
    @(negedge clk); chk("R10 page col 5 again", dout, 1'b1);
    ras_n = 1'b1;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); chk("R10 row close ends column access", dout, 1'b0);
    cas_n = 1'b1; ras_n = 1'b1; cs_n = 1'b1;

    // ---- R5 read with chip deselected
    read_cell(7'd64, 7'd5, 1'b1, v);
    chk("R5 dout 0 when deselected", v, 1'b0);

    // ---- R6 write with chip deselected
    write_cell(7'd64, 7'd5, 1'b0, 1'b1);
    read_cell(7'd64, 7'd5, 1'b0, v);
    chk("R6 deselected write ignored", v, 1'b1);

    // ---- R3 column strobe low before row strobe
    @(negedge clk); addr = 7'd5; din = 1'b0; rw = 1'b0; cs_n = 1'b0; cas_n = 1'b0;
    @(negedge clk); addr = 7'd64; ras_n = 1'b0;
    @(negedge clk); addr = 7'd5;
    @(negedge clk); cas_n = 1'b1; ras_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
    read_cell(7'd64, 7'd5, 1'b0, v);
    chk("R3 column-before-row ignored", v, 1'b1);

    // ---- R3 both strobes fall in the same clock
    @(negedge clk); addr = 7'd64; din = 1'b0; rw = 1'b0; cs_n = 1'b0;
    ras_n = 1'b0; cas_n = 1'b0;
    @(negedge clk); addr = 7'd6; din = 1'b1;
    @(negedge clk); cas_n = 1'b1; ras_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
    read_cell(7'd64, 7'd5, 1'b0, v);
    chk("R3 simultaneous fall no write col 5", v, 1'b1);
    read_cell(7'd64, 7'd6, 1'b0, v);
    chk("R3 simultaneous fall no write col 6", v, 1'b0);

    // ---- R7 row-only refresh leaves contents
    ras_only(7'd0);
    ras_only(7'd64);
    ras_only(7'd127);
    ras_only(7'd3);
    for (int i = 0; i < NVEC; i++) begin
      read_cell(VEC[i][14:8], VEC[i][7:1], 1'b0, v);
      chk($sformatf("R7 after refresh vector %0d", i), v,
          expect_bit(VEC[i][14:8], VEC[i][7:1]));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule